// File: doc/BRIEF.md
# Strobe-Synchronized Host Bus Interface

This block connects an asynchronous parallel host bus to logic clocked by a serial clock. The host starts each bus cycle by raising a strobe, with a read/write select, an address and (for writes) data presented on the bus. The strobe passes through a two-stage synchronizer and an edge detector. The bus fields are pipelined alongside it, so they only need to be valid on the first sampling edge that sees the strobe high. Each detected strobe rise turns into a single-cycle write enable or read enable toward the internal register space.

The `clk` input is the serial clock inverted. Every rising edge of `clk` is therefore a falling edge of the serial clock, and every latency below is counted in those edges. Reads and writes run on independent paths, each with its own latch, counter and one-deep hold slot. A read can therefore overlap a write still in progress, and the reverse also holds. A second cycle of the same type that arrives while the first is pending waits in the hold slot and is issued as soon as the first completes.

Read data returns through a latch that stays stable until the next read completes. One reserved address returns the ready flags of the internal shift buffers instead of register data. An optional registered ready output reports the ready flag of the currently addressed buffer, for hosts that use a hardware handshake instead of polling.

Top module: `host_strobe_if`

## Requirements
- R1: A synchronous active-high `rst` clears `reg_wr_en`, `reg_rd_en`, `host_rdy`, `host_rdata` and all pending and held requests, effective at the first edge it is sampled high.
- R2: If `host_stb` is first sampled high at edge E with `host_rnw`=0, `reg_wr_en` is high for exactly one cycle after edge E+2+LAT. `reg_wr_addr` and `reg_wr_data` then equal the values of `host_addr` and `host_wdata` at edge E, provided the write path is idle.
- R3: If `host_stb` is first sampled high at edge E with `host_rnw`=1, `reg_rd_en` is high for one cycle after edge E+2+LAT with `reg_rd_addr` equal to `host_addr` at E. At edge E+3+LAT, `host_rdata` takes the value of `reg_rd_data`.
- R4: `host_rdata` changes only at the edge after a cycle with `reg_rd_en` high, or on reset. It holds its value for any length of idle time and across writes.
- R5: The read and write paths are independent. A cycle of one type is never delayed by a pending cycle of the other type, so alternating reads and writes are accepted every second edge with no added latency.
- R6: For same-type cycles, let r be the edge at which a request reaches its path (first-high edge + 2). Service starts at max(r, previous same-type start + LAT), and the enable follows LAT edges after the start. A second request that arrives while the first is pending is held and is never dropped.
- R7: A strobe held high for any number of edges produces exactly one bus cycle. A new cycle needs the strobe to be sampled low at least once first.
- R8: A read of address STAT_ADDR (default 15) returns `buf_ready` in the low NBUF bits of `host_rdata`, with zeros above, sampled at the capture edge. Reads of other addresses return `reg_rd_data`.
- R9: With RDY_EN=1, `host_rdy` after each edge equals `buf_ready[host_addr]` when `host_addr` < NBUF, and 1 otherwise, using the values at that edge.
- R10: With at most two same-type cycles in flight, the hold slot never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Inverted serial clock; rising edges are the sampling edges |
| rst | input | 1 | Synchronous active-high reset |
| host_stb | input | 1 | Asynchronous host strobe, rising edge starts a cycle |
| host_rnw | input | 1 | 1 = read, 0 = write |
| host_addr | input | AW | Host address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Latched read data |
| host_rdy | output | 1 | Registered ready flag of the addressed shift buffer |
| buf_ready | input | NBUF | Ready flags of the internal shift buffers |
| reg_wr_en | output | 1 | Single-cycle internal write enable |
| reg_wr_addr | output | AW | Internal write address |
| reg_wr_data | output | DW | Internal write data |
| reg_rd_en | output | 1 | Single-cycle internal read enable |
| reg_rd_addr | output | AW | Internal read address |
| reg_rd_data | input | DW | Internal read data, valid in the cycle `reg_rd_en` is high |

## Verification
The bench drives strobes with one edge high and one edge low, which is the fastest legal rate. It mixes same-type pairs with alternating pairs. A design that shared one latch between the two paths would delay the read behind the write. A design without the hold slot would lose the second write, and a design that freed the path one edge late would issue it one edge late. A strobe held high for many edges catches a detector that retriggers on level. A status read, long idle stretches after a read, and a sweep of addresses across the buffer boundary catch a wrong status mux, a read latch that drifts, and a ready flag indexed past the buffer vector.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  // Path kinds; value matches the host read/write select encoding
  localparam logic KIND_WR = 1'b0;
  localparam logic KIND_RD = 1'b1;

  function automatic int cnt_width(input int lat);
    return (lat < 2) ? 1 : $clog2(lat + 1);
  endfunction
endpackage

// File: rtl/hsb_strobe_sync.sv
module hsb_strobe_sync #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb_i,
  input  logic          rnw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          req_o,
  output logic          rnw_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  localparam int BUSW = 1 + AW + DW;

  logic            meta_q, sync_q, prev_q;
  logic [BUSW-1:0] bus_q1, bus_q2;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
      bus_q1 <= '0;
      bus_q2 <= '0;
    end else begin
      meta_q <= stb_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
      bus_q1 <= {rnw_i, addr_i, data_i};
      bus_q2 <= bus_q1;
    end
  end

  // rising edge of the synchronized strobe, aligned with bus_q2
  assign req_o = sync_q & ~prev_q;
  assign {rnw_o, addr_o, data_o} = bus_q2;
endmodule

// File: rtl/hsb_cycle_path.sv
module hsb_cycle_path #(
  parameter int PW  = 12,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic [PW-1:0] pay_i,
  output logic          en_o,
  output logic [PW-1:0] pay_o,
  output logic          busy_o,
  output logic          ovf_o
);
  localparam int CW = hsb_pkg::cnt_width(LAT);
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  logic          busy_q, hold_v_q, en_q, ovf_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] cur_q, hold_q, out_q;
  logic          done, take;

  assign done = busy_q && (cnt_q == LAST);
  assign take = !busy_q || done;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      hold_v_q <= 1'b0;
      en_q     <= 1'b0;
      ovf_q    <= 1'b0;
      cnt_q    <= '0;
      cur_q    <= '0;
      hold_q   <= '0;
      out_q    <= '0;
    end else begin
      en_q  <= done;
      ovf_q <= 1'b0;
      if (done) out_q <= cur_q;
      if (take) begin
        cnt_q <= '0;
        if (hold_v_q) begin
          cur_q    <= hold_q;
          busy_q   <= 1'b1;
          hold_v_q <= req_i;
          if (req_i) hold_q <= pay_i;
        end else if (req_i) begin
          cur_q  <= pay_i;
          busy_q <= 1'b1;
        end else begin
          busy_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (req_i) begin
          if (hold_v_q) begin
            ovf_q <= 1'b1;
          end else begin
            hold_v_q <= 1'b1;
            hold_q   <= pay_i;
          end
        end
      end
    end
  end

  assign en_o   = en_q;
  assign pay_o  = out_q;
  assign busy_o = busy_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/hsb_read_return.sv
module hsb_read_return #(
  parameter int          AW        = 4,
  parameter int          DW        = 8,
  parameter int          NBUF      = 4,
  parameter int unsigned STAT_ADDR = 15,
  parameter bit          RDY_EN    = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  input  logic [DW-1:0]   rd_data,
  input  logic [NBUF-1:0] buf_ready,
  input  logic [AW-1:0]   host_addr,
  output logic [DW-1:0]   host_rdata,
  output logic            host_rdy
);
  localparam int BW = (NBUF > 1) ? $clog2(NBUF) : 1;

  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      if (rd_addr == AW'(STAT_ADDR)) rdata_q <= DW'(buf_ready);
      else                           rdata_q <= rd_data;
    end
  end
  assign host_rdata = rdata_q;

  generate
    if (RDY_EN) begin : g_rdy
      logic rdy_q;
      always_ff @(posedge clk) begin
        if (rst)                          rdy_q <= 1'b0;
        else if (host_addr < AW'(NBUF))   rdy_q <= buf_ready[host_addr[BW-1:0]];
        else                              rdy_q <= 1'b1;
      end
      assign host_rdy = rdy_q;
    end else begin : g_nordy
      assign host_rdy = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/host_strobe_if.sv
module host_strobe_if #(
  parameter int          AW        = 4,
  parameter int          DW        = 8,
  parameter int          NBUF      = 4,
  parameter int          LAT       = 3,
  parameter int unsigned STAT_ADDR = 15,
  parameter bit          RDY_EN    = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_stb,
  input  logic            host_rnw,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  output logic            host_rdy,
  input  logic [NBUF-1:0] buf_ready,
  output logic            reg_wr_en,
  output logic [AW-1:0]   reg_wr_addr,
  output logic [DW-1:0]   reg_wr_data,
  output logic            reg_rd_en,
  output logic [AW-1:0]   reg_rd_addr,
  input  logic [DW-1:0]   reg_rd_data
);
  import hsb_pkg::*;

  localparam int WPW = AW + DW;

  logic          sync_req, sync_rnw;
  logic [AW-1:0] sync_addr;
  logic [DW-1:0] sync_data;
  logic          wr_req, rd_req;
  logic          wr_busy, rd_busy, wr_ovf, rd_ovf;

  hsb_strobe_sync #(.AW(AW), .DW(DW)) u_sync (
    .clk(clk), .rst(rst),
    .stb_i(host_stb), .rnw_i(host_rnw), .addr_i(host_addr), .data_i(host_wdata),
    .req_o(sync_req), .rnw_o(sync_rnw), .addr_o(sync_addr), .data_o(sync_data)
  );

  assign wr_req = sync_req && (sync_rnw == KIND_WR);
  assign rd_req = sync_req && (sync_rnw == KIND_RD);

  hsb_cycle_path #(.PW(WPW), .LAT(LAT)) u_wr_path (
    .clk(clk), .rst(rst), .req_i(wr_req), .pay_i({sync_addr, sync_data}),
    .en_o(reg_wr_en), .pay_o({reg_wr_addr, reg_wr_data}),
    .busy_o(wr_busy), .ovf_o(wr_ovf)
  );

  hsb_cycle_path #(.PW(AW), .LAT(LAT)) u_rd_path (
    .clk(clk), .rst(rst), .req_i(rd_req), .pay_i(sync_addr),
    .en_o(reg_rd_en), .pay_o(reg_rd_addr),
    .busy_o(rd_busy), .ovf_o(rd_ovf)
  );

  hsb_read_return #(
    .AW(AW), .DW(DW), .NBUF(NBUF), .STAT_ADDR(STAT_ADDR), .RDY_EN(RDY_EN)
  ) u_ret (
    .clk(clk), .rst(rst), .rd_en(reg_rd_en), .rd_addr(reg_rd_addr),
    .rd_data(reg_rd_data), .buf_ready(buf_ready), .host_addr(host_addr),
    .host_rdata(host_rdata), .host_rdy(host_rdy)
  );
endmodule

// File: rtl/hsb_checker.sv
module hsb_checker #(
  parameter int DW  = 8,
  parameter int LAT = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr_en,
  input logic          reg_rd_en,
  input logic          host_rdy,
  input logic [DW-1:0] host_rdata,
  input logic          wr_busy,
  input logic          rd_busy,
  input logic          wr_ovf,
  input logic          rd_ovf
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (rst_q) begin
      rst_clears_chk: assert (!reg_wr_en && !reg_rd_en && !host_rdy && host_rdata == '0);
    end
  end

  // R2
  wr_from_busy_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> $past(wr_busy));

  // R3
  rd_from_busy_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd_en |-> $past(rd_busy));

  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(reg_rd_en) && !$past(rst)) |-> $stable(host_rdata));

  // R6
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (LAT > 1 && reg_wr_en) |=> !reg_wr_en);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_ovf && !rd_ovf);
endmodule

bind host_strobe_if hsb_checker #(.DW(DW), .LAT(LAT)) u_chk (
  .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
  .host_rdy(host_rdy), .host_rdata(host_rdata), .wr_busy(wr_busy),
  .rd_busy(rd_busy), .wr_ovf(wr_ovf), .rd_ovf(rd_ovf)
);

// File: tb/tb_host_strobe_if.sv
`timescale 1ns/1ps
module tb_host_strobe_if;
  localparam int AW = 4, DW = 8, NBUF = 4, LAT = 3;
  localparam int STAT = 15;

  logic clk = 1'b0, rst = 1'b1;
  logic host_stb = 1'b0, host_rnw = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic host_rdy;
  logic [NBUF-1:0] buf_ready = '0;
  logic reg_wr_en, reg_rd_en;
  logic [AW-1:0] reg_wr_addr, reg_rd_addr;
  logic [DW-1:0] reg_wr_data, reg_rd_data;

  always #2.5 clk = ~clk;

  // register space model: data is a function of the address
  assign reg_rd_data = {~reg_rd_addr, reg_rd_addr};

  host_strobe_if #(.AW(AW), .DW(DW), .NBUF(NBUF), .LAT(LAT), .STAT_ADDR(STAT), .RDY_EN(1'b1)) dut (
    .clk(clk), .rst(rst), .host_stb(host_stb), .host_rnw(host_rnw),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rdy(host_rdy), .buf_ready(buf_ready), .reg_wr_en(reg_wr_en),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
  );

  int errors = 0, checks = 0, ecount = 0, cycles = 0;
  bit run = 0, finished = 0;
  string cur_req = "R1";

  // reference model state
  int wq_edge[$], wq_addr[$], wq_data[$];
  int rq_edge[$], rq_addr[$];
  int last_wr = -100, last_rd = -100;
  bit rcap_pend = 0;
  int rcap_addr = 0;
  logic [DW-1:0] exp_rdata = '0;
  logic exp_rdy = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at edge %0d", req, what, act, exp, ecount);
    end
  endtask

  always @(posedge clk) begin
    ecount++;
    cycles++;
    if (rst) begin
      exp_rdy = 1'b0;
      exp_rdata = '0;
      rcap_pend = 0;
    end else begin
      exp_rdy = (host_addr < NBUF) ? buf_ready[host_addr[1:0]] : 1'b1;
      if (rcap_pend) begin
        exp_rdata = (rcap_addr == STAT) ? DW'(buf_ready) : {~rcap_addr[3:0], rcap_addr[3:0]};
        rcap_pend = 0;
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (run) begin
      bit ew, er;
      ew = (wq_edge.size() > 0) && (wq_edge[0] == ecount);
      er = (rq_edge.size() > 0) && (rq_edge[0] == ecount);
      check(reg_wr_en == ew, cur_req, "reg_wr_en", reg_wr_en, ew);
      if (ew) begin
        check(reg_wr_addr == wq_addr[0][AW-1:0], cur_req, "reg_wr_addr", reg_wr_addr, wq_addr[0]);
        check(reg_wr_data == wq_data[0][DW-1:0], cur_req, "reg_wr_data", reg_wr_data, wq_data[0]);
        void'(wq_edge.pop_front()); void'(wq_addr.pop_front()); void'(wq_data.pop_front());
      end
      check(reg_rd_en == er, cur_req, "reg_rd_en", reg_rd_en, er);
      if (er) begin
        check(reg_rd_addr == rq_addr[0][AW-1:0], cur_req, "reg_rd_addr", reg_rd_addr, rq_addr[0]);
        rcap_pend = 1;
        rcap_addr = rq_addr[0];
        void'(rq_edge.pop_front()); void'(rq_addr.pop_front());
      end
      check(host_rdata == exp_rdata, cur_req, "host_rdata", host_rdata, exp_rdata);
      check(host_rdy == exp_rdy, "R9", "host_rdy", host_rdy, exp_rdy);
    end
  end

  // caller is at a negedge; strobe high for hi edges, low for lo edges
  task automatic bus_cycle(input bit rnw, input int a, input int d, input int hi, input int lo);
    int e0, r, s;
    host_stb = 1'b1; host_rnw = rnw; host_addr = a[AW-1:0]; host_wdata = d[DW-1:0];
    e0 = ecount + 1;
    r = e0 + 2;
    if (rnw) begin
      s = (r > last_rd + LAT) ? r : last_rd + LAT;
      last_rd = s;
      rq_edge.push_back(s + LAT); rq_addr.push_back(a);
    end else begin
      s = (r > last_wr + LAT) ? r : last_wr + LAT;
      last_wr = s;
      wq_edge.push_back(s + LAT); wq_addr.push_back(a); wq_data.push_back(d);
    end
    repeat (hi) @(negedge clk);
    host_stb = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    check(!reg_wr_en && !reg_rd_en, "R1", "enables in reset", {reg_wr_en, reg_rd_en}, 0);
    check(host_rdy == 1'b0, "R1", "host_rdy in reset", host_rdy, 0);
    check(host_rdata == '0, "R1", "host_rdata in reset", host_rdata, 0);
    rst = 1'b0;
    run = 1;
    idle(2);

    cur_req = "R2";
    bus_cycle(1'b0, 3, 8'hA5, 3, 3);
    idle(8);

    cur_req = "R3";
    bus_cycle(1'b1, 6, 0, 3, 3);
    idle(8);
    cur_req = "R4";
    bus_cycle(1'b0, 7, 8'h3C, 2, 2);
    idle(20);

    cur_req = "R8";
    buf_ready = 4'b1010;
    idle(2);
    bus_cycle(1'b1, STAT, 0, 2, 2);
    idle(10);

    cur_req = "R5";
    bus_cycle(1'b0, 1, 8'h11, 1, 1);
    bus_cycle(1'b1, 2, 0, 1, 1);
    bus_cycle(1'b0, 4, 8'h44, 1, 1);
    bus_cycle(1'b1, 5, 0, 1, 1);
    idle(12);

    cur_req = "R6";
    bus_cycle(1'b0, 8, 8'h80, 1, 1);
    bus_cycle(1'b0, 9, 8'h91, 1, 1);
    idle(12);
    bus_cycle(1'b1, 10, 0, 1, 1);
    bus_cycle(1'b1, 11, 0, 1, 1);
    idle(12);

    cur_req = "R7";
    bus_cycle(1'b0, 12, 8'hC7, 9, 2);
    idle(10);

    cur_req = "R9";
    for (int i = 0; i < 16; i++) begin
      host_addr = i[AW-1:0];
      buf_ready = (i[0]) ? 4'b0101 : 4'b1011;
      idle(2);
    end
    idle(4);

    check(wq_edge.size() == 0, "R6", "writes outstanding", wq_edge.size(), 0);
    check(rq_edge.size() == 0, "R6", "reads outstanding", rq_edge.size(), 0);
    run = 0;
    finished = 1;
    summary();
  end

  always @(posedge clk) begin
    if (cycles > 5000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 5000);
      summary();
    end
  end
endmodule